// File: doc/BRIEF.md
# Access-aware DRAM refresh scheduler

This block sits beside a DRAM command sequencer and watches every row-activate that the sequencer issues for ordinary reads and writes. Opening a row recharges all of its cells just as a dedicated refresh does. The block therefore keeps one bit per bank and row that records whether the row has been opened in the current observation window. When the window closes, the set of rows nobody opened becomes the set of rows that must be refreshed explicitly.

The missed rows are handed to the sequencer one at a time on a request/acknowledge handshake. A steady streaming access pattern that sweeps every row once per window removes nearly all explicit refresh traffic. A sparse pattern falls back to full coverage. An activate that reaches a row still waiting for refresh withdraws that row's request. A count output reports how many rows the last window missed.

The window length is a number of pulses on a slow tick input. Each missed row is refreshed early in the following window, so the window must be set to at most half the cell retention time.

Top module: `acc_refresh_sched`

## Requirements
- R1: While rst_ni is low and after its release, rf_req_o is low and miss_cnt_o is zero, and no request is raised before the first window boundary.
- R2: A window boundary occurs on the cycle of the WINDOW_TICKS-th asserted win_tick_i pulse since the previous boundary; fewer pulses cause no boundary.
- R3: One cycle after a boundary, miss_cnt_o equals the number of bank/row pairs that saw no activate in the closing window; an activate on the boundary cycle itself belongs to the closing window. miss_cnt_o changes only at boundaries.
- R4: Only rows that missed an activate in the closing window are requested; a fully covered window raises no request.
- R5: Missed rows are requested in ascending linear index, index = row*BANKS + bank (row order first, bank within row).
- R6: While rf_req_o is high and neither rf_ack_i nor a matching activate occurs, rf_req_o stays high and rf_bank_o/rf_row_o stay stable.
- R7: rf_ack_i with rf_req_o high retires the request: rf_req_o is low in the next cycle and that row is not requested again in the window.
- R8: An activate whose bank and row equal the pending request cancels it: rf_req_o is low in the next cycle and the row is not requested again in the window.
- R9: An activate of a missed row that has not yet been requested removes that row from the refresh list.
- R10: The activate record is cleared at each boundary, so a row opened in one window but not in the next is missed at the end of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_valid_i | input | 1 | A row-activate is being issued this cycle |
| act_bank_i | input | $clog2(BANKS) | Bank of the activate |
| act_row_i | input | $clog2(ROWS) | Row of the activate |
| win_tick_i | input | 1 | Window time-base pulse |
| rf_req_o | output | 1 | Explicit refresh requested |
| rf_bank_o | output | $clog2(BANKS) | Bank to refresh |
| rf_row_o | output | $clog2(ROWS) | Row to refresh |
| rf_ack_i | input | 1 | Sequencer has taken the refresh request |
| miss_cnt_o | output | $clog2(BANKS*ROWS+1) | Rows missed in the last closed window |

## Verification
The checker assumes that rf_ack_i is asserted only while rf_req_o is high. It also assumes that activate bank and row values are always in range, since BANKS and ROWS are powers of two. The stimulus raises the acknowledge only after it has seen a request at a falling edge, and drops it one cycle later. It drives every activate and tick for exactly one cycle. Cancellation is provoked on purpose by an activate aimed at the request on display, and in a second case at a row still queued behind it.

// File: rtl/acc_refresh_pkg.sv
package acc_refresh_pkg;
  // width able to hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/win_timer.sv
module win_timer #(
  parameter int unsigned TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic end_o
);
  localparam int unsigned CW = acc_refresh_pkg::cnt_w(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign end_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/touch_map.sv
module touch_map #(
  parameter int unsigned N  = 256,
  parameter int unsigned BW = 2,
  parameter int unsigned RW = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 act_valid_i,
  input  logic [BW-1:0]                        act_bank_i,
  input  logic [RW-1:0]                        act_row_i,
  input  logic                                 win_end_i,
  output logic [N-1:0]                         act_mask_o,
  output logic [N-1:0]                         closed_o,
  output logic [acc_refresh_pkg::cnt_w(N)-1:0] miss_cnt_o
);
  localparam int unsigned CW = acc_refresh_pkg::cnt_w(N);

  logic [N-1:0]      touched_q;
  logic [RW+BW-1:0]  act_idx;
  logic [CW-1:0]     miss_sum;

  assign act_idx = {act_row_i, act_bank_i};

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign act_mask_o[i] = act_valid_i && (act_idx == (RW+BW)'(i));
  end

  // rows covered in the closing window, boundary-cycle activate included
  assign closed_o = touched_q | act_mask_o;

  always_comb begin
    miss_sum = '0;
    for (int i = 0; i < N; i++) miss_sum = miss_sum + CW'(!closed_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      touched_q  <= '0;
      miss_cnt_o <= '0;
    end else if (win_end_i) begin
      touched_q  <= '0;
      miss_cnt_o <= miss_sum;
    end else begin
      touched_q  <= closed_o;
    end
  end
endmodule

// File: rtl/refresh_walker.sv
module refresh_walker #(
  parameter int unsigned N  = 256,
  parameter int unsigned BW = 2,
  parameter int unsigned RW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_end_i,
  input  logic [N-1:0]  closed_i,
  input  logic [N-1:0]  act_mask_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o
);
  localparam int unsigned IW = RW + BW;

  logic [N-1:0]  pend_q, pend_d;
  logic [IW-1:0] cur_q, pick;
  logic          any, drop;

  assign drop = req_o && (ack_i || act_mask_i[cur_q]);

  always_comb begin
    pend_d = win_end_i ? ~closed_i : (pend_q & ~act_mask_i);
    if (req_o && ack_i) pend_d[cur_q] = 1'b0;
  end

  // lowest set index wins
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_d[i]) begin
        pick = IW'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cur_q  <= '0;
      req_o  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (req_o) begin
        if (drop) req_o <= 1'b0;
      end else if (any) begin
        req_o <= 1'b1;
        cur_q <= pick;
      end
    end
  end

  assign bank_o = cur_q[BW-1:0];
  assign row_o  = cur_q[IW-1:BW];
endmodule

// File: rtl/acc_refresh_sched.sv
module acc_refresh_sched #(
  parameter int unsigned BANKS        = 4,
  parameter int unsigned ROWS         = 64,
  parameter int unsigned WINDOW_TICKS = 1000,
  localparam int unsigned N  = BANKS * ROWS,
  localparam int unsigned BW = $clog2(BANKS),
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = acc_refresh_pkg::cnt_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_valid_i,
  input  logic [BW-1:0] act_bank_i,
  input  logic [RW-1:0] act_row_i,
  input  logic          win_tick_i,
  output logic          rf_req_o,
  output logic [BW-1:0] rf_bank_o,
  output logic [RW-1:0] rf_row_o,
  input  logic          rf_ack_i,
  output logic [CW-1:0] miss_cnt_o
);
  logic         win_end;
  logic [N-1:0] act_mask, closed;

  win_timer #(.TICKS(WINDOW_TICKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(win_tick_i),
    .end_o (win_end)
  );

  touch_map #(.N(N), .BW(BW), .RW(RW)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_valid_i(act_valid_i),
    .act_bank_i (act_bank_i),
    .act_row_i  (act_row_i),
    .win_end_i  (win_end),
    .act_mask_o (act_mask),
    .closed_o   (closed),
    .miss_cnt_o (miss_cnt_o)
  );

  refresh_walker #(.N(N), .BW(BW), .RW(RW)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_i (win_end),
    .closed_i  (closed),
    .act_mask_i(act_mask),
    .ack_i     (rf_ack_i),
    .req_o     (rf_req_o),
    .bank_o    (rf_bank_o),
    .row_o     (rf_row_o)
  );
endmodule

// File: rtl/acc_refresh_chk.sv
module acc_refresh_chk #(
  parameter int unsigned BANKS = 4,
  parameter int unsigned ROWS  = 64,
  localparam int unsigned N  = BANKS * ROWS,
  localparam int unsigned BW = $clog2(BANKS),
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = acc_refresh_pkg::cnt_w(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          act_valid_i,
  input logic [BW-1:0] act_bank_i,
  input logic [RW-1:0] act_row_i,
  input logic          rf_req_o,
  input logic [BW-1:0] rf_bank_o,
  input logic [RW-1:0] rf_row_o,
  input logic          rf_ack_i,
  input logic [CW-1:0] miss_cnt_o,
  input logic          win_end
);
  logic hit;
  assign hit = act_valid_i && (act_bank_i == rf_bank_o) && (act_row_i == rf_row_o);

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && !rf_ack_i && !hit) |=> (rf_req_o && $stable(rf_bank_o) && $stable(rf_row_o)));

  // R7
  ack_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && rf_ack_i) |=> !rf_req_o);

  // R8
  act_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && hit) |=> !rf_req_o);

  // R3
  miss_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(miss_cnt_o));

  // R3
  miss_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o <= CW'(N));

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rf_req_o && miss_cnt_o == '0));
endmodule

bind acc_refresh_sched acc_refresh_chk #(.BANKS(BANKS), .ROWS(ROWS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_valid_i(act_valid_i),
  .act_bank_i (act_bank_i),
  .act_row_i  (act_row_i),
  .rf_req_o   (rf_req_o),
  .rf_bank_o  (rf_bank_o),
  .rf_row_o   (rf_row_o),
  .rf_ack_i   (rf_ack_i),
  .miss_cnt_o (miss_cnt_o),
  .win_end    (win_end)
);

// File: tb/acc_refresh_sched_tb.sv
module acc_refresh_sched_tb;
  localparam int unsigned BANKS = 2;
  localparam int unsigned ROWS  = 8;
  localparam int unsigned TICKS = 3;
  localparam int unsigned N     = BANKS * ROWS;
  localparam int unsigned BW    = $clog2(BANKS);
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned CW    = acc_refresh_pkg::cnt_w(N);
  localparam time CLK_PERIOD    = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          act_valid_i = 1'b0;
  logic [BW-1:0] act_bank_i = '0;
  logic [RW-1:0] act_row_i = '0;
  logic          win_tick_i = 1'b0;
  logic          rf_req_o;
  logic [BW-1:0] rf_bank_o;
  logic [RW-1:0] rf_row_o;
  logic          rf_ack_i = 1'b0;
  logic [CW-1:0] miss_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  logic [N-1:0] tch = '0;
  logic [N-1:0] exp_miss = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_refresh_sched #(.BANKS(BANKS), .ROWS(ROWS), .WINDOW_TICKS(TICKS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_valid_i(act_valid_i),
    .act_bank_i(act_bank_i), .act_row_i(act_row_i), .win_tick_i(win_tick_i),
    .rf_req_o(rf_req_o), .rf_bank_o(rf_bank_o), .rf_row_o(rf_row_o),
    .rf_ack_i(rf_ack_i), .miss_cnt_o(miss_cnt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_zero(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += (m[i] == 1'b0) ? 1 : 0;
    return c;
  endfunction

  // one-cycle activate, idx = row*BANKS + bank
  task automatic act(input int idx);
    @(negedge clk_i);
    act_valid_i = 1'b1;
    act_bank_i  = BW'(idx % BANKS);
    act_row_i   = RW'(idx / BANKS);
    tch[idx]    = 1'b1;
    @(negedge clk_i);
    act_valid_i = 1'b0;
  endtask

  task automatic tick(input bit with_act, input int idx);
    @(negedge clk_i);
    win_tick_i = 1'b1;
    if (with_act) begin
      act_valid_i = 1'b1;
      act_bank_i  = BW'(idx % BANKS);
      act_row_i   = RW'(idx / BANKS);
      tch[idx]    = 1'b1;
    end
    @(negedge clk_i);
    win_tick_i  = 1'b0;
    act_valid_i = 1'b0;
  endtask

  task automatic end_window(input bit with_act, input int idx);
    for (int k = 0; k < TICKS - 1; k++) tick(1'b0, 0);
    tick(with_act, idx);
    exp_miss = ~tch;
    tch = '0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      if (rf_req_o) seen = 1'b1;
      else @(negedge clk_i);
    end
  endtask

  // R4 R5 R6 R7: expect every set bit of exp in ascending order
  task automatic drain(input logic [N-1:0] exp);
    bit seen;
    for (int i = 0; i < N; i++) begin
      if (exp[i]) begin
        wait_req(seen);
        check("R4 request present", int'(seen), 1);
        check("R5 request index", int'(rf_row_o) * BANKS + int'(rf_bank_o), i);
        @(negedge clk_i);
        check("R6 held req", int'(rf_req_o), 1);
        check("R6 held index", int'(rf_row_o) * BANKS + int'(rf_bank_o), i);
        rf_ack_i = 1'b1;
        @(negedge clk_i);
        rf_ack_i = 1'b0;
        check("R7 retired", int'(rf_req_o), 0);
      end
    end
    repeat (4) @(negedge clk_i);
    check("R7 no further request", int'(rf_req_o), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    bit seen;
    logic [N-1:0] m;
    repeat (3) @(negedge clk_i);
    check("R1 req in reset", int'(rf_req_o), 0);
    check("R1 count in reset", int'(miss_cnt_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 idle after reset", int'(rf_req_o), 0);

    // window 0: even indices touched
    for (int i = 0; i < N; i += 2) act(i);
    for (int k = 0; k < TICKS - 1; k++) tick(1'b0, 0);
    repeat (2) @(negedge clk_i);
    check("R2 no early boundary count", int'(miss_cnt_o), 0);
    check("R2 no early boundary req", int'(rf_req_o), 0);
    tick(1'b0, 0);
    exp_miss = ~tch; tch = '0;
    check("R2 R3 boundary count", int'(miss_cnt_o), N / 2);
    drain(exp_miss);

    // window 1: nothing touched; R10 rows from window 0 missed now
    end_window(1'b0, 0);
    check("R10 R3 all missed", int'(miss_cnt_o), N);
    drain(exp_miss);

    // window 2: full coverage
    for (int i = 0; i < N; i++) act(i);
    end_window(1'b0, 0);
    check("R4 R3 covered count", int'(miss_cnt_o), 0);
    repeat (6) @(negedge clk_i);
    check("R4 covered no req", int'(rf_req_o), 0);

    // window 3: idx%3==0, plus idx 1 on the boundary cycle
    for (int i = 0; i < N; i += 3) act(i);
    end_window(1'b1, 1);
    check("R3 boundary activate counted", int'(miss_cnt_o), cnt_zero(~exp_miss));
    drain(exp_miss);

    // window 4: nothing touched, then cancellations in window 5
    end_window(1'b0, 0);
    check("R3 count all", int'(miss_cnt_o), N);
    wait_req(seen);
    check("R8 first req idx", int'(rf_row_o) * BANKS + int'(rf_bank_o), 0);
    act(0);
    check("R8 cancelled", int'(rf_req_o), 0);
    act(2);
    m = exp_miss;
    m[0] = 1'b0;
    m[2] = 1'b0;
    drain(m);  // R9 index 2 skipped
    end_window(1'b0, 0);
    check("R10 new window count", int'(miss_cnt_o), N - 2);
    drain(exp_miss);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule